// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This unit moves a register value by exactly one bit position, left or right, and decides which bit enters the vacated end. The choice comes from a three-bit fill selector in the instruction. It can pick the incoming carry, the operand's top bit, the operand's bottom bit, a constant 0 or a constant 1. That one selector is enough to express logical shifts, shifts through carry, sign-extending right shifts and rotates in both directions. No separate rotate or arithmetic decode is needed.

The datapath is purely combinational. The shifted value, the bit pushed out and the zero indication follow the inputs within the same cycle. A pair of flag registers captures the new carry and zero only when an execute strobe arrives together with the shift/rotate opcode. The surrounding core therefore sees the flags change one clock after the instruction executes.

Top module: `sru_top`

## Requirements
- R1: The flag registers `flag_c_q` and `flag_z_q` load only on a rising clock edge where `exec_en` is 1 and `opcode` equals 6'b100000. In every other cycle they keep their value.
- R2: With `dir` = 0 (left), `result` is `data_in` moved up one position with the fill bit in bit 0, and `carry_out` equals the old bit W-1.
- R3: With `dir` = 1 (right), `result` is `data_in` moved down one position with the fill bit in bit W-1, and `carry_out` equals the old bit 0.
- R4: `fill_sel` values 3'b000 and 3'b001 insert `carry_in`.
- R5: `fill_sel` values 3'b010 and 3'b011 insert `data_in[W-1]`. Left with this code is a rotate left, and right with this code is a sign-extending shift.
- R6: `fill_sel` values 3'b100 and 3'b101 insert `data_in[0]`. Right with this code is a rotate right.
- R7: `fill_sel` 3'b110 inserts a constant 0, and 3'b111 inserts a constant 1.
- R8: `zero_out` is 1 exactly when all W bits of `result` are 0.
- R9: While `rst_n` is low at a rising edge, both flag registers clear to 0.
- R10: After an enabled shift/rotate edge, `flag_c_q` and `flag_z_q` hold the `carry_out` and `zero_out` values present just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Execute strobe for the current instruction |
| opcode | input | 6 | Instruction opcode; 6'b100000 selects this unit |
| dir | input | 1 | Direction: 0 left, 1 right |
| fill_sel | input | 3 | Source of the bit entering the vacated end |
| carry_in | input | 1 | Present carry flag of the core |
| data_in | input | W (8) | Operand value |
| result | output | W (8) | Shifted or rotated value |
| carry_out | output | 1 | Bit pushed out of the operand |
| zero_out | output | 1 | Result-is-zero indication |
| flag_c_q | output | 1 | Registered carry flag |
| flag_z_q | output | 1 | Registered zero flag |

## Verification
The bench walks through every mnemonic in both directions with operands whose top and bottom bits differ. A swapped MSB/LSB fill or a wrong carry source shows up as a single wrong bit at the incoming end. The bench also feeds a value whose only set bit is pushed out, to confirm zero rises while carry is set. A zero flag computed from the operand instead of the result would stay low there. Strobes with the wrong opcode, or with `exec_en` low, must leave both flags untouched; a decoder that ignores either qualifier would overwrite them. Finally, a sweep of operands against all selector values and both carry states catches a don't-care bit that the design decodes when it should not.

// File: rtl/sru_pkg.sv
// Package: shared constants and the fill-source type for the shift/rotate unit.
// Assumes the fill selector is three bits wide; bit 0 only matters for the
// constant codes.
package sru_pkg;

    localparam logic [5:0] SHROT_OPCODE = 6'b100000;

    typedef enum logic [1:0] {
        FILL_CARRY = 2'b00,
        FILL_MSB   = 2'b01,
        FILL_LSB   = 2'b10,
        FILL_CONST = 2'b11
    } fill_src_e;

endpackage

// File: rtl/sru_fill_mux.sv
// Module: picks the single bit entering the vacated end of the operand.
// Assumes the upper two selector bits choose the source; the low bit is a
// don't-care except for the constant source, where it is the constant itself.
module sru_fill_mux
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   fill_sel,
    input  logic         carry_in,
    input  logic [W-1:0] data_in,
    output logic         fill_bit
);

    fill_src_e src;

    assign src = fill_src_e'(fill_sel[2:1]);

    // Select the fill source from the decoded selector
    always_comb begin
        unique case (src)
            FILL_CARRY: fill_bit = carry_in;
            FILL_MSB:   fill_bit = data_in[W-1];
            FILL_LSB:   fill_bit = data_in[0];
            FILL_CONST: fill_bit = fill_sel[0];
            default:    fill_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sru_shifter.sv
// Module: one-position shift in either direction with an external fill bit.
// Assumes W >= 2. Reports the bit that leaves the operand and whether the
// result is all zeros.
module sru_shifter #(
    parameter int W = 8
) (
    input  logic         dir,
    input  logic         fill_bit,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         zero_out
);

    logic [W-1:0] up_val;
    logic [W-1:0] down_val;

    // Build both shifted candidates bit by bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign up_val[i]   = fill_bit;
            assign down_val[i] = data_in[i+1];
        end else if (i == W-1) begin : g_high
            assign up_val[i]   = data_in[i-1];
            assign down_val[i] = fill_bit;
        end else begin : g_mid
            assign up_val[i]   = data_in[i-1];
            assign down_val[i] = data_in[i+1];
        end
    end

    // Choose the direction and the bit that is pushed out
    always_comb begin
        result    = dir ? down_val : up_val;
        carry_out = dir ? data_in[0] : data_in[W-1];
        zero_out  = ~|result;
    end

endmodule

// File: rtl/sru_flag_reg.sv
// Module: carry and zero flag storage with a load enable.
// Assumes reset is synchronous and active low; reset wins over load.
module sru_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic carry_d,
    input  logic zero_d,
    output logic carry_q,
    output logic zero_q
);

    // Clear on reset, capture new flags on load, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (load) begin
            carry_q <= carry_d;
            zero_q  <= zero_d;
        end
    end

endmodule

// File: rtl/sru_top.sv
// Module: shift/rotate unit top. Combinational one-bit shift with a selectable
// fill source, plus registered flags that load only for the shift/rotate
// opcode under the execute strobe.
// Assumes the caller presents a stable instruction for the whole cycle.
module sru_top
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_en,
    input  logic [5:0]   opcode,
    input  logic         dir,
    input  logic [2:0]   fill_sel,
    input  logic         carry_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         zero_out,
    output logic         flag_c_q,
    output logic         flag_z_q
);

    logic fill_bit;
    logic flag_load;

    // Flags load only for this unit's opcode under the execute strobe
    always_comb flag_load = exec_en && (opcode == SHROT_OPCODE);

    sru_fill_mux #(.W(W)) u_fill (
        .fill_sel (fill_sel),
        .carry_in (carry_in),
        .data_in  (data_in),
        .fill_bit (fill_bit)
    );

    sru_shifter #(.W(W)) u_shift (
        .dir       (dir),
        .fill_bit  (fill_bit),
        .data_in   (data_in),
        .result    (result),
        .carry_out (carry_out),
        .zero_out  (zero_out)
    );

    sru_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (flag_load),
        .carry_d (carry_out),
        .zero_d  (zero_out),
        .carry_q (flag_c_q),
        .zero_q  (flag_z_q)
    );

endmodule

// File: rtl/sru_checker.sv
// Module: assertion checker for sru_top, attached through bind.
// Assumes it sees the top-level ports only.
module sru_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exec_en,
    input logic [5:0]   opcode,
    input logic         dir,
    input logic [2:0]   fill_sel,
    input logic         carry_in,
    input logic [W-1:0] data_in,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         zero_out,
    input logic         flag_c_q,
    input logic         flag_z_q
);

    // R1
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_en && opcode == 6'b100000) |=> ($stable(flag_c_q) && $stable(flag_z_q)));

    // R2
    left_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> (carry_out == data_in[W-1] && result[W-1:1] == data_in[W-2:0]));

    // R3
    right_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> (carry_out == data_in[0] && result[W-2:0] == data_in[W-1:1]));

    // R4
    carry_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel[2:1] == 2'b00 && !dir) |-> result[0] == carry_in);

    // R6
    lsb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel[2:1] == 2'b10 && dir) |-> result[W-1] == data_in[0]);

    // R7
    const_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_sel[2:1] == 2'b11 && !dir) |-> result[0] == fill_sel[0]);

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result == '0) |-> zero_out);

    // R10
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 6'b100000) |=>
            (flag_c_q == $past(carry_out) && flag_z_q == $past(zero_out)));

endmodule

bind sru_top sru_checker #(.W(W)) u_sru_checker (.*);

// File: tb/tb_sru_top.sv
// Directed bench for sru_top: one task per scenario, each checking itself
// against a behavioural model of the selector and shift rules.
module tb_sru_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         exec_en;
    logic [5:0]   opcode;
    logic         dir;
    logic [2:0]   fill_sel;
    logic         carry_in;
    logic [W-1:0] data_in;
    logic [W-1:0] result;
    logic         carry_out;
    logic         zero_out;
    logic         flag_c_q;
    logic         flag_z_q;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    sru_top #(.W(W)) dut (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural model of the shifted value
    function automatic logic [W:0] model(input logic d, input logic [2:0] s,
                                         input logic c, input logic [W-1:0] v);
        logic f;
        case (s[2:1])
            2'b00:   f = c;
            2'b01:   f = v[W-1];
            2'b10:   f = v[0];
            default: f = s[0];
        endcase
        if (d) model = {v[0], f, v[W-1:1]};
        else   model = {v[W-1], v[W-2:0], f};
    endfunction

    // Drive one instruction at the falling edge and compare the datapath
    task automatic apply(input logic d, input logic [2:0] s, input logic c,
                         input logic [W-1:0] v, input logic en, input logic [5:0] op,
                         input string req);
        logic [W:0] e;
        @(negedge clk);
        dir = d; fill_sel = s; carry_in = c; data_in = v; exec_en = en; opcode = op;
        #1;
        e = model(d, s, c, v);
        check(result == e[W-1:0], req, result, e[W-1:0]);
        check(carry_out == e[W], req, carry_out, e[W]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; exec_en = 1'b1; opcode = 6'b100000;
        dir = 1'b0; fill_sel = 3'b111; carry_in = 1'b1; data_in = 8'hFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(flag_c_q == 1'b0, "R9 carry", flag_c_q, 0);
        check(flag_z_q == 1'b0, "R9 zero", flag_z_q, 0);
        exec_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_left_mnemonics();
        apply(1'b0, 3'b110, 1'b1, 8'hB5, 1'b0, 6'h00, "R7 SL0");
        apply(1'b0, 3'b111, 1'b0, 8'h34, 1'b0, 6'h00, "R7 SL1");
        apply(1'b0, 3'b100, 1'b0, 8'h81, 1'b0, 6'h00, "R6 SLX");
        apply(1'b0, 3'b000, 1'b1, 8'h42, 1'b0, 6'h00, "R4 SLA");
        apply(1'b0, 3'b010, 1'b0, 8'h80, 1'b0, 6'h00, "R5 RL");
        check(result == 8'h01, "R2 rotate left", result, 8'h01);
    endtask

    task automatic t_right_mnemonics();
        apply(1'b1, 3'b110, 1'b1, 8'hB5, 1'b0, 6'h00, "R7 SR0");
        check(result == 8'h5A, "R3 SR0 value", result, 8'h5A);
        apply(1'b1, 3'b111, 1'b0, 8'h34, 1'b0, 6'h00, "R7 SR1");
        apply(1'b1, 3'b010, 1'b0, 8'h84, 1'b0, 6'h00, "R5 SRX");
        check(result == 8'hC2, "R5 sign extend", result, 8'hC2);
        apply(1'b1, 3'b000, 1'b1, 8'h10, 1'b0, 6'h00, "R4 SRA");
        apply(1'b1, 3'b100, 1'b0, 8'h01, 1'b0, 6'h00, "R6 RR");
        check(result == 8'h80, "R6 rotate right", result, 8'h80);
    endtask

    task automatic t_zero_and_flags();
        apply(1'b0, 3'b110, 1'b0, 8'h80, 1'b1, 6'b100000, "R2 out bit");
        check(zero_out == 1'b1, "R8 zero set", zero_out, 1);
        @(negedge clk);
        check(flag_c_q == 1'b1, "R10 carry load", flag_c_q, 1);
        check(flag_z_q == 1'b1, "R10 zero load", flag_z_q, 1);
        exec_en = 1'b0;
        apply(1'b1, 3'b111, 1'b0, 8'h00, 1'b0, 6'h00, "R3 fill one");
        check(zero_out == 1'b0, "R8 zero clear", zero_out, 0);
    endtask

    task automatic t_gating();
        // Flags hold 1/1 from the previous task; try to overwrite with 0/0
        apply(1'b1, 3'b111, 1'b0, 8'h02, 1'b1, 6'b100001, "R1 wrong opcode");
        @(negedge clk);
        check(flag_c_q == 1'b1 && flag_z_q == 1'b1, "R1 wrong opcode hold",
              {flag_c_q, flag_z_q}, 3);
        apply(1'b1, 3'b111, 1'b0, 8'h02, 1'b0, 6'b100000, "R1 no strobe");
        @(negedge clk);
        check(flag_c_q == 1'b1 && flag_z_q == 1'b1, "R1 no strobe hold",
              {flag_c_q, flag_z_q}, 3);
        apply(1'b1, 3'b111, 1'b0, 8'h02, 1'b1, 6'b100000, "R10 enabled");
        @(negedge clk);
        check(flag_c_q == 1'b0 && flag_z_q == 1'b0, "R10 enabled load",
              {flag_c_q, flag_z_q}, 0);
        exec_en = 1'b0;
    endtask

    task automatic t_sweep();
        for (int v = 3; v < 256; v += 37) begin
            for (int s = 0; s < 8; s++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(d[0], s[2:0], c[0], v[W-1:0], 1'b0, 6'h00,
                              d[0] ? "R3 sweep" : "R2 sweep");
                        check(zero_out == (result == '0), "R8 sweep", zero_out, result == '0);
                    end
                end
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_left_mnemonics();
        t_right_mnemonics();
        t_zero_and_flags();
        t_gating();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule